// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the general and status registers of a 32-bit processor that runs in one unprivileged mode and several privileged modes. Sixteen architectural indices are visible at any moment; the current mode, taken from the low five bits of the current status word, decides which of 31 physical general registers each index reaches. Five exception modes each own a saved status word. User mode and the system mode share one view of all sixteen indices. The fast-interrupt mode has its own copies of indices 8 to 14. The interrupt, supervisor, abort and undefined modes each have their own copies of indices 13 and 14 only. Index 13 serves as the stack pointer, index 14 as the link register and index 15 as the program counter, which is shared by all modes.

The register file has two combinational read ports and one write port for the general registers. It also has a read and write path for the current status word and for the saved status word of the current mode. It provides an exception-entry operation. In a single clock edge, this operation switches the mode field to the target mode, copies the old status word into the target mode's saved status word, and writes a return address into the target mode's link register. Every state change takes effect at the clock edge, so accesses in a given cycle always see the mode and contents from before that edge.

Top module: `banked_regfile`

## Requirements
- R1: After the active-low asynchronous reset, the current status word reads 0x000000D3 (supervisor mode, both interrupt-disable bits set) and every general register reads 0.
- R2: Mode codes are held in status bits [4:0]: user 0x10, fast interrupt 0x11, interrupt 0x12, supervisor 0x13, abort 0x17, undefined 0x1B, system 0x1F. The user and system modes see the same physical register for every index 0 to 15, so a write in one mode is read back in the other.
- R3: In fast-interrupt mode, indices 8 to 14 reach registers private to that mode. Indices 0 to 7 and index 15 reach the shared registers.
- R4: The interrupt, supervisor, abort and undefined modes each reach a private register for index 13 and a private register for index 14. All other indices reach the shared registers.
- R5: Both read ports return the addressed register combinationally and independently. A read of an index that is being written in the same cycle returns the old value; the new value is visible from the next cycle.
- R6: A write to the current status word replaces it at the next edge. A general write in the same cycle still uses the mapping of the old mode, and the new mode governs accesses from the next cycle.
- R7: In an exception mode, the saved-status port reads and writes that mode's own saved word. In user, system or an unrecognised mode, the saved-status read returns the current status word and a saved-status write is ignored.
- R8: Exception entry to a target exception mode sets status bits [4:0] to the target code and keeps bits [31:5]. It copies the old status word into the target mode's saved word and writes the return address into the target mode's index-14 register. All of these changes appear in the next cycle.
- R9: When exception entry coincides with other writes, the following rules apply. A general write uses the old mode's mapping. Where it hits the same physical register as the link write, the link write wins. The exception entry overrides a status write in the same cycle and a saved-status write to the target's saved word.
- R10: Exception entry whose target is not one of the five exception codes is ignored; any general write in that cycle still takes effect. Any status mode code outside the seven listed maps like user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_a_idx_i | input | 4 | Read port A index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 4 | Read port B index |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | General register write enable |
| wr_idx_i | input | 4 | General register write index |
| wr_data_i | input | 32 | General register write data |
| st_wr_en_i | input | 1 | Current status write enable |
| st_wr_data_i | input | 32 | Current status write data |
| st_rd_o | output | 32 | Current status word |
| sv_wr_en_i | input | 1 | Saved status write enable (current mode) |
| sv_wr_data_i | input | 32 | Saved status write data |
| sv_rd_o | output | 32 | Saved status word of current mode |
| exc_en_i | input | 1 | Exception entry request |
| exc_mode_i | input | 5 | Exception target mode code |
| exc_ret_i | input | 32 | Return address for the target link register |

## Verification
Exception entry and an ordinary register-file write can land on the same clock edge, and the way they interact is the main concurrency risk. The bench drives both in one cycle in three cases. In the first, a general write and a link write hit the same physical index-14 register during a same-mode re-entry. In the second, the general write lands in the old mode's bank while the link write lands in a different bank. In the third, a status write and a saved-status write are applied together with the entry. After each case, the bench switches through the affected modes and compares every index and both status words against a bench model that applies the write, then the link write, then the status overrides. This ordering lets it show which write won.

// File: rtl/brf_pkg.sv
package brf_pkg;
  localparam int unsigned ARCH_REGS = 16;
  localparam int unsigned AW        = $clog2(ARCH_REGS);
  localparam int unsigned PHYS_REGS = 31;
  localparam int unsigned PW        = $clog2(PHYS_REGS);
  localparam int unsigned SAVED_CNT = 5;
  localparam int unsigned MW        = 5;
  localparam int unsigned BW        = 3;

  localparam logic [MW-1:0] MODE_USR = 5'h10;
  localparam logic [MW-1:0] MODE_FIQ = 5'h11;
  localparam logic [MW-1:0] MODE_IRQ = 5'h12;
  localparam logic [MW-1:0] MODE_SVC = 5'h13;
  localparam logic [MW-1:0] MODE_ABT = 5'h17;
  localparam logic [MW-1:0] MODE_UND = 5'h1B;
  localparam logic [MW-1:0] MODE_SYS = 5'h1F;

  // bank 0 = shared view (user, system, unknown); 1..5 = exception banks
  function automatic logic [BW-1:0] bank_of(input logic [MW-1:0] m);
    case (m)
      MODE_FIQ: return 3'd1;
      MODE_IRQ: return 3'd2;
      MODE_SVC: return 3'd3;
      MODE_ABT: return 3'd4;
      MODE_UND: return 3'd5;
      default:  return 3'd0;
    endcase
  endfunction

  // 0..15 shared, 16..22 fast-irq 8..14, 23..30 pairs of 13/14 for banks 2..5
  function automatic logic [PW-1:0] phys_of(input logic [BW-1:0] b, input logic [AW-1:0] idx);
    logic [PW-1:0] p;
    p = {1'b0, idx};
    if (b == 3'd1 && idx >= 4'd8 && idx <= 4'd14)
      p = 5'd16 + {1'b0, idx} - 5'd8;
    else if (b >= 3'd2 && (idx == 4'd13 || idx == 4'd14))
      p = 5'd23 + {1'b0, b - 3'd2, 1'b0} + {4'd0, ~idx[0]};
    return p;
  endfunction
endpackage

// File: rtl/brf_decode.sv
module brf_decode
  import brf_pkg::*;
#(
  parameter int unsigned NPORT = 3
) (
  input  logic [MW-1:0]            mode_i,
  input  logic [NPORT-1:0][AW-1:0] idx_i,
  output logic [NPORT-1:0][PW-1:0] pidx_o
);
  logic [BW-1:0] bank;
  assign bank = bank_of(mode_i);

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    assign pidx_o[g] = phys_of(bank, idx_i[g]);
  end
endmodule

// File: rtl/brf_gpr_array.sv
module brf_gpr_array #(
  parameter int unsigned DW   = 32,
  parameter int unsigned NREG = 31,
  parameter int unsigned NRD  = 2,
  localparam int unsigned PW  = $clog2(NREG)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NRD-1:0][PW-1:0] rd_pidx_i,
  output logic [NRD-1:0][DW-1:0] rd_data_o,
  input  logic                   wr_en_i,
  input  logic [PW-1:0]          wr_pidx_i,
  input  logic [DW-1:0]          wr_data_i,
  input  logic                   lnk_en_i,
  input  logic [PW-1:0]          lnk_pidx_i,
  input  logic [DW-1:0]          lnk_data_i
);
  logic [DW-1:0] regs_q [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs_q[r] <= '0;
      else if (lnk_en_i && lnk_pidx_i == PW'(r))
        regs_q[r] <= lnk_data_i;  // link write wins
      else if (wr_en_i && wr_pidx_i == PW'(r))
        regs_q[r] <= wr_data_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data_o[p] = regs_q[rd_pidx_i[p]];
  end
endmodule

// File: rtl/brf_status.sv
module brf_status
  import brf_pkg::*;
#(
  parameter int unsigned DW            = 32,
  parameter logic [DW-1:0] RST_STATUS  = 32'h0000_00D3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          st_wr_en_i,
  input  logic [DW-1:0] st_wr_data_i,
  input  logic          sv_wr_en_i,
  input  logic [DW-1:0] sv_wr_data_i,
  input  logic          exc_en_i,
  input  logic [MW-1:0] exc_mode_i,
  output logic [DW-1:0] cur_o,
  output logic [DW-1:0] sv_rd_o
);
  logic [DW-1:0] cur_q;
  logic [DW-1:0] saved_q [SAVED_CNT];
  logic [BW-1:0] cur_bank, tgt_bank;

  assign cur_bank = bank_of(cur_q[MW-1:0]);
  assign tgt_bank = bank_of(exc_mode_i);
  assign cur_o    = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cur_q <= RST_STATUS;
    else if (exc_en_i)   cur_q <= {cur_q[DW-1:MW], exc_mode_i};
    else if (st_wr_en_i) cur_q <= st_wr_data_i;
  end

  for (genvar k = 0; k < SAVED_CNT; k++) begin : g_saved
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        saved_q[k] <= '0;
      else if (exc_en_i && tgt_bank == BW'(k + 1))
        saved_q[k] <= cur_q;
      else if (sv_wr_en_i && cur_bank == BW'(k + 1))
        saved_q[k] <= sv_wr_data_i;
    end
  end

  always_comb begin
    sv_rd_o = cur_q;
    for (int k = 0; k < SAVED_CNT; k++)
      if (cur_bank == BW'(k + 1)) sv_rd_o = saved_q[k];
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
#(
  parameter int unsigned DW           = 32,
  parameter logic [DW-1:0] RST_STATUS = 32'h0000_00D3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [3:0]    rd_a_idx_i,
  output logic [DW-1:0] rd_a_data_o,
  input  logic [3:0]    rd_b_idx_i,
  output logic [DW-1:0] rd_b_data_o,
  input  logic          wr_en_i,
  input  logic [3:0]    wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          st_wr_en_i,
  input  logic [DW-1:0] st_wr_data_i,
  output logic [DW-1:0] st_rd_o,
  input  logic          sv_wr_en_i,
  input  logic [DW-1:0] sv_wr_data_i,
  output logic [DW-1:0] sv_rd_o,
  input  logic          exc_en_i,
  input  logic [4:0]    exc_mode_i,
  input  logic [DW-1:0] exc_ret_i
);
  localparam int unsigned NPORT = 3;
  localparam logic [AW-1:0] LINK_IDX = 4'd14;

  logic [DW-1:0]            cur;
  logic                     exc_ok;
  logic [NPORT-1:0][AW-1:0] idx;
  logic [NPORT-1:0][PW-1:0] pidx;
  logic [1:0][DW-1:0]       rdata;
  logic [PW-1:0]            lnk_pidx;

  assign exc_ok   = exc_en_i && (bank_of(exc_mode_i) != 3'd0);
  assign lnk_pidx = phys_of(bank_of(exc_mode_i), LINK_IDX);
  assign idx      = {wr_idx_i, rd_b_idx_i, rd_a_idx_i};

  brf_decode #(.NPORT(NPORT)) u_dec (
    .mode_i (cur[MW-1:0]),
    .idx_i  (idx),
    .pidx_o (pidx)
  );

  brf_gpr_array #(.DW(DW), .NREG(PHYS_REGS), .NRD(2)) u_gpr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_pidx_i  ({pidx[1], pidx[0]}),
    .rd_data_o  (rdata),
    .wr_en_i    (wr_en_i),
    .wr_pidx_i  (pidx[2]),
    .wr_data_i  (wr_data_i),
    .lnk_en_i   (exc_ok),
    .lnk_pidx_i (lnk_pidx),
    .lnk_data_i (exc_ret_i)
  );

  brf_status #(.DW(DW), .RST_STATUS(RST_STATUS)) u_st (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .st_wr_en_i   (st_wr_en_i),
    .st_wr_data_i (st_wr_data_i),
    .sv_wr_en_i   (sv_wr_en_i),
    .sv_wr_data_i (sv_wr_data_i),
    .exc_en_i     (exc_ok),
    .exc_mode_i   (exc_mode_i),
    .cur_o        (cur),
    .sv_rd_o      (sv_rd_o)
  );

  assign rd_a_data_o = rdata[0];
  assign rd_b_data_o = rdata[1];
  assign st_rd_o     = cur;
endmodule

// File: rtl/brf_checker.sv
module brf_checker
  import brf_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [3:0]    rd_a_idx_i,
  input logic [DW-1:0] rd_a_data_o,
  input logic          wr_en_i,
  input logic [3:0]    wr_idx_i,
  input logic [DW-1:0] wr_data_i,
  input logic          st_wr_en_i,
  input logic [DW-1:0] st_wr_data_i,
  input logic [DW-1:0] st_rd_o,
  input logic [DW-1:0] sv_rd_o,
  input logic          exc_en_i,
  input logic [4:0]    exc_mode_i
);
  logic exc_valid;
  assign exc_valid = exc_en_i && (bank_of(exc_mode_i) != 3'd0);

  // R5: a plain write is visible through port A from the next cycle
  p_write_visible_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !exc_en_i && !st_wr_en_i) |=>
      (rd_a_idx_i != $past(wr_idx_i) || rd_a_data_o == $past(wr_data_i)));

  // R6
  p_status_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_wr_en_i && !exc_valid) |=> st_rd_o == $past(st_wr_data_i));

  // R7
  p_shared_saved_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_of(st_rd_o[4:0]) == 3'd0) |-> sv_rd_o == st_rd_o);

  // R8
  p_exc_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid |=> st_rd_o[4:0] == $past(exc_mode_i));

  p_exc_saved_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid |=> sv_rd_o == $past(st_rd_o));

  // R9
  p_exc_over_status_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid && st_wr_en_i) |=> st_rd_o[DW-1:5] == $past(st_rd_o[DW-1:5]));

  // R10
  p_bad_target_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_en_i && !exc_valid && !st_wr_en_i) |=> $stable(st_rd_o));
endmodule

bind banked_regfile brf_checker #(.DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rd_a_idx_i   (rd_a_idx_i),
  .rd_a_data_o  (rd_a_data_o),
  .wr_en_i      (wr_en_i),
  .wr_idx_i     (wr_idx_i),
  .wr_data_i    (wr_data_i),
  .st_wr_en_i   (st_wr_en_i),
  .st_wr_data_i (st_wr_data_i),
  .st_rd_o      (st_rd_o),
  .sv_rd_o      (sv_rd_o),
  .exc_en_i     (exc_en_i),
  .exc_mode_i   (exc_mode_i)
);

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, st_we = 1'b0, sv_we = 1'b0, exc_en = 1'b0;
  logic [31:0] st_wd = '0, sv_wd = '0, st_rd, sv_rd, exc_ret = '0;
  logic [4:0]  exc_mode = '0;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  banked_regfile u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_a_idx_i(rd_a_idx), .rd_a_data_o(rd_a_data),
    .rd_b_idx_i(rd_b_idx), .rd_b_data_o(rd_b_data),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .st_wr_en_i(st_we), .st_wr_data_i(st_wd), .st_rd_o(st_rd),
    .sv_wr_en_i(sv_we), .sv_wr_data_i(sv_wd), .sv_rd_o(sv_rd),
    .exc_en_i(exc_en), .exc_mode_i(exc_mode), .exc_ret_i(exc_ret)
  );

  localparam logic [4:0] USR = 5'h10, FIQ = 5'h11, IRQ = 5'h12, SVC = 5'h13;
  localparam logic [4:0] ABT = 5'h17, UND = 5'h1B, SYS = 5'h1F;

  // bench model: shared view, fast-irq 8..14, per-bank 13/14, saved words
  logic [31:0] m_sh  [16];
  logic [31:0] m_fq  [7];
  logic [31:0] m_r13 [6];
  logic [31:0] m_r14 [6];
  logic [31:0] m_sv  [6];
  logic [31:0] m_st;

  function automatic int mbank(input logic [4:0] m);
    case (m)
      FIQ: return 1; IRQ: return 2; SVC: return 3; ABT: return 4; UND: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] mget(input int b, input int i);
    if (b == 1 && i >= 8 && i <= 14) return m_fq[i-8];
    if (b >= 2 && i == 13) return m_r13[b];
    if (b >= 2 && i == 14) return m_r14[b];
    return m_sh[i];
  endfunction

  task automatic mput(input int b, input int i, input logic [31:0] d);
    if (b == 1 && i >= 8 && i <= 14) m_fq[i-8] = d;
    else if (b >= 2 && i == 13) m_r13[b] = d;
    else if (b >= 2 && i == 14) m_r14[b] = d;
    else m_sh[i] = d;
  endtask

  function automatic logic [31:0] sv_exp();
    int b;
    b = mbank(m_st[4:0]);
    return (b == 0) ? m_st : m_sv[b];
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // one clock: drive before the edge, model applies write, link, status overrides
  task automatic cyc(input logic we, input logic [3:0] wi, input logic [31:0] wd,
                     input logic stw, input logic [31:0] std,
                     input logic svw, input logic [31:0] svd,
                     input logic ex, input logic [4:0] em, input logic [31:0] ea);
    int ob, tb;
    logic [31:0] ost;
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_data = wd;
    st_we = stw; st_wd = std; sv_we = svw; sv_wd = svd;
    exc_en = ex; exc_mode = em; exc_ret = ea;
    ob = mbank(m_st[4:0]); ost = m_st; tb = mbank(em);
    if (we) mput(ob, int'(wi), wd);
    if (svw && ob != 0) m_sv[ob] = svd;
    if (stw) m_st = std;
    if (ex && tb != 0) begin
      mput(tb, 14, ea);
      m_sv[tb] = ost;
      m_st = {ost[31:5], em};
    end
    @(posedge clk); #1;
    wr_en = 1'b0; st_we = 1'b0; sv_we = 1'b0; exc_en = 1'b0;
  endtask

  task automatic set_mode(input logic [4:0] m);
    cyc(1'b0, 4'd0, '0, 1'b1, {m_st[31:5], m}, 1'b0, '0, 1'b0, 5'h0, '0);
  endtask

  task automatic view(input string tag);
    chk(tag, "status", st_rd, m_st);
    chk(tag, "saved", sv_rd, sv_exp());
    for (int i = 0; i < 16; i++) begin
      rd_a_idx = 4'(i); rd_b_idx = 4'(15 - i);
      #1;
      chk(tag, $sformatf("portA idx %0d mode %h", i, m_st[4:0]), rd_a_data, mget(mbank(m_st[4:0]), i));
      chk(tag, $sformatf("portB idx %0d mode %h", 15 - i, m_st[4:0]), rd_b_data, mget(mbank(m_st[4:0]), 15 - i));
    end
  endtask

  function automatic string mtag(input logic [4:0] m);
    case (m)
      USR, SYS: return "R2";
      FIQ:      return "R3";
      IRQ, SVC, ABT, UND: return "R4";
      default:  return "R10";
    endcase
  endfunction

  logic [4:0] modes [8];

  initial begin
    modes = '{USR, FIQ, IRQ, SVC, ABT, UND, SYS, 5'h15};
    for (int i = 0; i < 16; i++) m_sh[i] = '0;
    for (int i = 0; i < 7; i++) m_fq[i] = '0;
    for (int i = 0; i < 6; i++) begin m_r13[i] = '0; m_r14[i] = '0; m_sv[i] = '0; end
    m_st = 32'h0000_00D3;

    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "reset status", st_rd, 32'h0000_00D3);
    view("R1");

    // R2 R3 R4 R10: fill each mode's view, then read every view back
    foreach (modes[k]) begin
      set_mode(modes[k]);
      for (int i = 0; i < 16; i++)
        cyc(1'b1, 4'(i), 32'hC000_0000 | (32'(modes[k]) << 8) | 32'(i),
            1'b0, '0, 1'b0, '0, 1'b0, 5'h0, '0);
    end
    foreach (modes[k]) begin
      set_mode(modes[k]);
      view(mtag(modes[k]));
    end

    // R5: same-cycle read returns old value, new value next cycle
    set_mode(USR);
    @(negedge clk);
    rd_a_idx = 4'd3; rd_b_idx = 4'd3;
    wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'h5A5A_0003;
    #1;
    chk("R5", "portA old", rd_a_data, mget(0, 3));
    chk("R5", "portB old", rd_b_data, mget(0, 3));
    mput(0, 3, 32'h5A5A_0003);
    @(posedge clk); #1;
    wr_en = 1'b0;
    #1;
    chk("R5", "portA new", rd_a_data, 32'h5A5A_0003);
    chk("R5", "portB new", rd_b_data, 32'h5A5A_0003);

    // R6: mode change with same-cycle write uses old mapping
    cyc(1'b1, 4'd9, 32'h6666_0009, 1'b1, {m_st[31:5], FIQ}, 1'b0, '0, 1'b0, 5'h0, '0);
    chk("R6", "mode now fiq", {27'd0, st_rd[4:0]}, {27'd0, FIQ});
    view("R6");
    set_mode(USR);
    view("R6");

    // R7: saved words per exception mode, ignored in shared modes
    set_mode(SVC);
    cyc(1'b0, 4'd0, '0, 1'b0, '0, 1'b1, 32'h7777_0003, 1'b0, 5'h0, '0);
    view("R7");
    set_mode(IRQ);
    cyc(1'b0, 4'd0, '0, 1'b0, '0, 1'b1, 32'h7777_0002, 1'b0, 5'h0, '0);
    view("R7");
    set_mode(USR);
    cyc(1'b0, 4'd0, '0, 1'b0, '0, 1'b1, 32'hDEAD_0000, 1'b0, 5'h0, '0);
    view("R7");
    set_mode(SYS);
    cyc(1'b0, 4'd0, '0, 1'b0, '0, 1'b1, 32'hDEAD_0001, 1'b0, 5'h0, '0);
    view("R7");
    set_mode(SVC); view("R7");
    set_mode(IRQ); view("R7");
    set_mode(FIQ); view("R7");

    // R8: exception entry from user with flags set
    cyc(1'b0, 4'd0, '0, 1'b1, 32'hF000_0010, 1'b0, '0, 1'b0, 5'h0, '0);
    cyc(1'b0, 4'd0, '0, 1'b0, '0, 1'b0, '0, 1'b1, IRQ, 32'h0000_1234);
    chk("R8", "status after entry", st_rd, 32'hF000_0012);
    chk("R8", "saved after entry", sv_rd, 32'hF000_0010);
    view("R8");
    set_mode(USR);
    view("R8");

    // R9: concurrent writes with exception entry
    set_mode(SVC);
    cyc(1'b1, 4'd14, 32'h9999_0014, 1'b1, 32'h1234_5678, 1'b1, 32'hBBBB_0000,
        1'b1, SVC, 32'h0000_ABCD);
    view("R9");
    cyc(1'b1, 4'd5, 32'h9999_0005, 1'b0, '0, 1'b0, '0, 1'b1, ABT, 32'h0000_5555);
    view("R9");
    set_mode(USR);
    cyc(1'b1, 4'd14, 32'h9999_000E, 1'b0, '0, 1'b0, '0, 1'b1, FIQ, 32'h0000_4444);
    view("R9");
    set_mode(USR);
    view("R9");

    // R10: bad exception targets ignored, unknown mode maps like user
    set_mode(ABT);
    cyc(1'b1, 4'd13, 32'hAAAA_000D, 1'b0, '0, 1'b0, '0, 1'b1, SYS, 32'h0000_0BAD);
    view("R10");
    cyc(1'b0, 4'd0, '0, 1'b0, '0, 1'b0, '0, 1'b1, 5'h14, 32'h0000_0BAD);
    view("R10");
    set_mode(5'h0A);
    view("R10");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule